// File: doc/BRIEF.md
# Sidetone Filter Control and Coefficient Loader

This block is the register-side front end of an audio sidetone filter. It keeps the filter's run enable, an automatic idle control bit and two signed 16-bit channel gains. It also holds a bank of filter taps that the filter datapath reads through a dedicated combinational read port. Software reaches the block over a simple 32-bit read/write bus in which each register sits at a fixed byte offset.

Taps are not individually addressed. Software first raises a load-enable bit in the control register. It then writes the taps one after another to a single coefficient port, and the block places each value at the next tap index. Once the last tap has been written, a read-only completion bit rises in the control register. Software then drops the load-enable bit. Each new rise of the load-enable bit starts the sequence again at tap 0.

Top module: `sidetone_cfg_top`

## Requirements
- R1: After synchronous reset, `st_enable` is 0, `auto_idle` is 1, and both gains are 0. The control register (offset 0x2C) reads 0, and the system configuration register (offset 0x10) reads 1.
- R2: A read at offset 0x00 returns the constant `REV_VALUE`. Writes to that offset change nothing.
- R3: Bit 0 of the system configuration register (offset 0x10) is the auto-idle control. It reads back as written, and `auto_idle` follows it from the clock edge that takes the write.
- R4: The gain register (offset 0x24) holds the channel 0 gain in bits 15:0 and the channel 1 gain in bits 31:16. It reads back as written, and `gain_ch0` and `gain_ch1` take the new values on the edge that takes the write.
- R5: Control register bit 0 is the sidetone enable. It reads back as written and drives `st_enable` from the next edge.
- R6: Writing control bit 1 as 1 while it reads 0 restarts the load at tap 0 and clears the done bit. Writing 1 while it already reads 1 neither restarts nor moves the tap index.
- R7: While control bit 1 is set, each write to the coefficient port (offset 0x28) stores bits 15:0 of the write data at the next tap in ascending order, starting from tap 0. The stored value is returned on `tap_rdata` when `tap_raddr` selects that tap.
- R8: Writes to the coefficient port while control bit 1 is clear change no stored tap and do not set the done bit.
- R9: Control bit 2 (done) reads 1 from the cycle after the NUM_TAPS-th coefficient write of a load, and not before that write. It returns to 0 when bit 1 is written as 0.
- R10: Coefficient writes after the NUM_TAPS-th write of a load change no stored tap, and done stays 1.
- R11: Control bit 2 is read-only: writing it as 1 does not set it.
- R12: Reads of the coefficient port and of offsets with no register (such as 0x04 and 0x18) return 0. Reads return 0 in any cycle with no read access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data in the same cycle as the read access |
| tap_raddr | input | log2(NUM_TAPS) | Tap index for the filter datapath |
| tap_rdata | output | 16 | Tap value at `tap_raddr` |
| st_enable | output | 1 | Sidetone enable |
| auto_idle | output | 1 | Automatic idle control |
| gain_ch0 | output | 16 | Signed channel 0 gain |
| gain_ch1 | output | 16 | Signed channel 1 gain |

## Verification
The bench builds the block with its default parameters: 128 taps and a 16-bit tap width. With those values the full 128-write load, the exact write that raises done, and writes past the end are all reached on the real depth. A behavioural model follows the load index and the tap values on every cycle and checks each tap against the port. The directed sequences cover a repeated load-enable write in the middle of a load, a restart in the middle of a load, and coefficient writes while loading is off.

// File: rtl/sidetone_cfg_pkg.sv
package sidetone_cfg_pkg;

    localparam int REG_AW = 8;
    localparam int BUS_DW = 32;
    localparam int GAIN_W = 16;
    localparam int COEF_W = 16;

    localparam logic [REG_AW-1:0] OFS_REV    = 8'h00;
    localparam logic [REG_AW-1:0] OFS_SYSCFG = 8'h10;
    localparam logic [REG_AW-1:0] OFS_GAIN   = 8'h24;
    localparam logic [REG_AW-1:0] OFS_COEF   = 8'h28;
    localparam logic [REG_AW-1:0] OFS_CTRL   = 8'h2C;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_LOAD_BIT  = 1;
    localparam int SYSCFG_IDLE_BIT = 0;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_REV,
        RSEL_SYSCFG,
        RSEL_GAIN,
        RSEL_COEF,
        RSEL_CTRL
    } rsel_e;

    typedef struct packed {
        logic signed [GAIN_W-1:0] ch1;
        logic signed [GAIN_W-1:0] ch0;
    } gain_pair_t;

    typedef struct packed {
        logic done;
        logic load;
        logic en;
    } ctrl_view_t;

    typedef struct packed {
        logic              wr;
        logic              rd;
        rsel_e             sel;
        logic [BUS_DW-1:0] data;
    } bus_op_t;

    function automatic rsel_e decode_offset(input logic [REG_AW-1:0] a);
        rsel_e s;
        case (a)
            OFS_REV:    s = RSEL_REV;
            OFS_SYSCFG: s = RSEL_SYSCFG;
            OFS_GAIN:   s = RSEL_GAIN;
            OFS_COEF:   s = RSEL_COEF;
            OFS_CTRL:   s = RSEL_CTRL;
            default:    s = RSEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [BUS_DW-1:0] ctrl_word(input ctrl_view_t v);
        return {{(BUS_DW-3){1'b0}}, v};
    endfunction

endpackage

// File: rtl/st_ctrl_regs.sv
module st_ctrl_regs
    import sidetone_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_syscfg,
    input  logic              wr_gain,
    input  logic              wr_ctrl,
    input  logic [BUS_DW-1:0] wdata,
    output logic              st_enable,
    output logic              auto_idle,
    output gain_pair_t        gains
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_enable <= 1'b0;
            auto_idle <= 1'b1;
            gains     <= '0;
        end else begin
            if (wr_syscfg) auto_idle <= wdata[SYSCFG_IDLE_BIT];
            if (wr_gain)   gains     <= gain_pair_t'(wdata);
            if (wr_ctrl)   st_enable <= wdata[CTRL_EN_BIT];
        end
    end

    // R4
    gain_update_chk: assert property (@(posedge clk) disable iff (rst)
        wr_gain |=> gains == $past(wdata));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_syscfg |=> $stable(auto_idle));

    // R5
    enable_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(st_enable));

endmodule

// File: rtl/st_coef_loader.sv
module st_coef_loader
    import sidetone_cfg_pkg::*;
#(
    parameter int NUM_TAPS = 128,
    localparam int TAP_AW  = $clog2(NUM_TAPS),
    localparam int IDX_W   = $clog2(NUM_TAPS + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              load_bit,
    input  logic              coef_wr,
    input  logic [COEF_W-1:0] coef_data,
    output logic              load_en,
    output logic              load_done,
    output logic              mem_we,
    output logic [TAP_AW-1:0] mem_waddr,
    output logic [COEF_W-1:0] mem_wdata
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TAPS - 1);
    localparam logic [IDX_W-1:0] FULL_IDX = IDX_W'(NUM_TAPS);

    logic [IDX_W-1:0] idx;
    logic             take;
    logic             start;

    assign take  = coef_wr && load_en && (idx < FULL_IDX);
    assign start = ctrl_wr && load_bit && !load_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_en   <= 1'b0;
            load_done <= 1'b0;
            idx       <= '0;
        end else if (ctrl_wr) begin
            load_en <= load_bit;
            if (start) begin
                idx       <= '0;
                load_done <= 1'b0;
            end else if (!load_bit) begin
                load_done <= 1'b0;
            end
        end else if (take) begin
            idx <= idx + 1'b1;
            if (idx == LAST_IDX) load_done <= 1'b1;
        end
    end

    assign mem_we    = take;
    assign mem_waddr = idx[TAP_AW-1:0];
    assign mem_wdata = coef_data;

    // R10
    idx_bound_chk: assert property (@(posedge clk) disable iff (rst)
        idx <= FULL_IDX);

    // R9
    done_full_chk: assert property (@(posedge clk) disable iff (rst)
        load_done |-> (idx == FULL_IDX) && load_en);

    // R8
    idle_write_chk: assert property (@(posedge clk) disable iff (rst)
        (coef_wr && !load_en) |=> $stable(idx) && !$rose(load_done));

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (idx == '0) && !load_done);

    // R6
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && load_bit && load_en) |=> $stable(idx));

    // R9
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(load_done) |-> $past(coef_wr));

endmodule

// File: rtl/st_coef_mem.sv
module st_coef_mem #(
    parameter int NUM_TAPS = 128,
    parameter int WIDTH    = 16,
    localparam int TAP_AW  = $clog2(NUM_TAPS)
)(
    input  logic              clk,
    input  logic              we,
    input  logic [TAP_AW-1:0] waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [TAP_AW-1:0] raddr,
    output logic [WIDTH-1:0]  rdata
);

    logic [WIDTH-1:0] bank [NUM_TAPS];

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        logic [WIDTH-1:0] q;
        always_ff @(posedge clk) begin
            if (we && (waddr == TAP_AW'(g))) q <= wdata;
        end
        assign bank[g] = q;
    end

    assign rdata = bank[raddr];

endmodule

// File: rtl/sidetone_cfg_top.sv
module sidetone_cfg_top
    import sidetone_cfg_pkg::*;
#(
    parameter int          NUM_TAPS  = 128,
    parameter logic [31:0] REV_VALUE = 32'h0000_0021,
    localparam int         TAP_AW    = $clog2(NUM_TAPS)
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_en,
    input  logic                     bus_we,
    input  logic [REG_AW-1:0]        bus_addr,
    input  logic [BUS_DW-1:0]        bus_wdata,
    output logic [BUS_DW-1:0]        bus_rdata,
    input  logic [TAP_AW-1:0]        tap_raddr,
    output logic [COEF_W-1:0]        tap_rdata,
    output logic                     st_enable,
    output logic                     auto_idle,
    output logic signed [GAIN_W-1:0] gain_ch0,
    output logic signed [GAIN_W-1:0] gain_ch1
);

    bus_op_t           op;
    gain_pair_t        gains;
    logic              load_en;
    logic              load_done;
    logic              mem_we;
    logic [TAP_AW-1:0] mem_waddr;
    logic [COEF_W-1:0] mem_wdata;

    assign op.wr   = bus_en && bus_we;
    assign op.rd   = bus_en && !bus_we;
    assign op.sel  = decode_offset(bus_addr);
    assign op.data = bus_wdata;

    st_ctrl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_syscfg (op.wr && (op.sel == RSEL_SYSCFG)),
        .wr_gain   (op.wr && (op.sel == RSEL_GAIN)),
        .wr_ctrl   (op.wr && (op.sel == RSEL_CTRL)),
        .wdata     (op.data),
        .st_enable (st_enable),
        .auto_idle (auto_idle),
        .gains     (gains)
    );

    st_coef_loader #(.NUM_TAPS(NUM_TAPS)) u_load (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (op.wr && (op.sel == RSEL_CTRL)),
        .load_bit  (op.data[CTRL_LOAD_BIT]),
        .coef_wr   (op.wr && (op.sel == RSEL_COEF)),
        .coef_data (op.data[COEF_W-1:0]),
        .load_en   (load_en),
        .load_done (load_done),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata)
    );

    st_coef_mem #(.NUM_TAPS(NUM_TAPS), .WIDTH(COEF_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (tap_raddr),
        .rdata (tap_rdata)
    );

    always_comb begin
        bus_rdata = '0;
        if (op.rd) begin
            case (op.sel)
                RSEL_REV:    bus_rdata = REV_VALUE;
                RSEL_SYSCFG: bus_rdata = {{(BUS_DW-1){1'b0}}, auto_idle};
                RSEL_GAIN:   bus_rdata = gains;
                RSEL_CTRL:   bus_rdata = ctrl_word('{done: load_done, load: load_en, en: st_enable});
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign gain_ch0 = gains.ch0;
    assign gain_ch1 = gains.ch1;

    // R12
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !op.rd |-> bus_rdata == '0);

    // R11
    done_readonly_chk: assert property (@(posedge clk) disable iff (rst)
        (op.wr && op.sel == RSEL_CTRL && !load_done) |=> !load_done);

endmodule

// File: tb/sidetone_cfg_top_test.sv
`timescale 1ns/1ps
module sidetone_cfg_top_test;

    localparam int          NT  = 128;
    localparam logic [31:0] REV = 32'h0000_0021;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  tap_raddr = '0;
    logic [15:0] tap_rdata;
    logic        st_enable;
    logic        auto_idle;
    logic signed [15:0] gain_ch0;
    logic signed [15:0] gain_ch1;

    always #2 clk = ~clk;

    sidetone_cfg_top #(.NUM_TAPS(NT), .REV_VALUE(REV)) uut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tap_raddr(tap_raddr), .tap_rdata(tap_rdata),
        .st_enable(st_enable), .auto_idle(auto_idle),
        .gain_ch0(gain_ch0), .gain_ch1(gain_ch1)
    );

    int total = 0;
    int bad   = 0;

    // behavioural reference model
    bit          m_en, m_idle, m_load, m_done;
    logic [15:0] m_g0, m_g1;
    int          m_idx;
    logic [15:0] m_tap [NT];
    bit          m_ok  [NT];

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_idle = 1; m_load = 0; m_done = 0;
            m_g0 = 0; m_g1 = 0; m_idx = 0;
        end else if (bus_en && bus_we) begin
            case (bus_addr)
                8'h10: m_idle = bus_wdata[0];
                8'h24: begin m_g0 = bus_wdata[15:0]; m_g1 = bus_wdata[31:16]; end
                8'h28: if (m_load && m_idx < NT) begin
                    m_tap[m_idx] = bus_wdata[15:0];
                    m_ok[m_idx]  = 1;
                    m_idx++;
                    if (m_idx == NT) m_done = 1;
                end
                8'h2C: begin
                    m_en = bus_wdata[0];
                    if (bus_wdata[1] && !m_load) begin m_idx = 0; m_done = 0; end
                    if (!bus_wdata[1]) m_done = 0;
                    m_load = bus_wdata[1];
                end
                default: ;
            endcase
        end
    end

    function automatic logic [31:0] exp_rd();
        if (!(bus_en && !bus_we)) return 32'h0;
        case (bus_addr)
            8'h00:   return REV;
            8'h10:   return {31'h0, m_idle};
            8'h24:   return {m_g1, m_g0};
            8'h2C:   return {29'h0, m_done, m_load, m_en};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    logic [31:0] last_rd;
    logic [15:0] last_tap;

    task automatic cyc(input logic en, input logic we, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
        #1;
        last_rd  = bus_rdata;
        last_tap = tap_rdata;
        if (!rst) begin
            chk("R5 model st_enable", {31'h0, st_enable}, {31'h0, m_en});
            chk("R3 model auto_idle", {31'h0, auto_idle}, {31'h0, m_idle});
            chk("R4 model gain_ch0", {16'h0, gain_ch0}, {16'h0, m_g0});
            chk("R4 model gain_ch1", {16'h0, gain_ch1}, {16'h0, m_g1});
            chk("R12 model rdata", bus_rdata, exp_rd());
            if (m_ok[tap_raddr]) chk("R7 model tap", {16'h0, tap_rdata}, {16'h0, m_tap[tap_raddr]});
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b1, a, d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        cyc(1'b1, 1'b0, a, 32'h0);
        v = last_rd;
    endtask

    task automatic peek(input int i, output logic [15:0] v);
        tap_raddr = 7'(i);
        cyc(1'b0, 1'b0, 8'h00, 32'h0);
        v = last_tap;
    endtask

    function automatic logic [31:0] pat_a(input int i);
        logic [15:0] x;
        x = 16'(i * 1237 + 16'h0321) ^ 16'(i << 9);
        return {16'hDEAD, x};
    endfunction

    function automatic logic [31:0] pat_b(input int i);
        logic [15:0] x;
        x = ~pat_a(i)[15:0] + 16'(i);
        return {16'hC0DE, x};
    endfunction

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [15:0] t;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 st_enable", {31'h0, st_enable}, 32'h0);
        chk("R1 auto_idle", {31'h0, auto_idle}, 32'h1);
        chk("R1 gains", {gain_ch1, gain_ch0}, 32'h0);
        rd(8'h2C, v); chk("R1 ctrl read", v, 32'h0);
        rd(8'h10, v); chk("R1 syscfg read", v, 32'h1);

        // R2 revision
        rd(8'h00, v); chk("R2 rev", v, REV);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R2 rev after write", v, REV);

        // R3 auto-idle
        wr(8'h10, 32'h0);
        rd(8'h10, v); chk("R3 syscfg read", v, 32'h0);
        chk("R3 auto_idle out", {31'h0, auto_idle}, 32'h0);

        // R4 gains
        wr(8'h24, 32'h8001_7FFF);
        rd(8'h24, v); chk("R4 gain read", v, 32'h8001_7FFF);
        chk("R4 ch0", {16'h0, gain_ch0}, 32'h7FFF);
        chk("R4 ch1", {16'h0, gain_ch1}, 32'h8001);
        wr(8'h24, 32'hFFFE_0003);
        rd(8'h24, v); chk("R4 gain read 2", v, 32'hFFFE_0003);
        chk("R4 ch0 second", {16'h0, gain_ch0}, 32'h0003);

        // R5 enable
        wr(8'h2C, 32'h1);
        rd(8'h2C, v); chk("R5 ctrl read", v, 32'h1);
        chk("R5 st_enable out", {31'h0, st_enable}, 32'h1);

        // R8 coefficient write before any load
        wr(8'h28, 32'h0000_1111);
        rd(8'h2C, v); chk("R8 ctrl after idle write", v, 32'h1);

        // load with a repeated load-enable write mid-way (R6, R7, R9)
        wr(8'h2C, 32'h3);
        for (int i = 0; i < 5; i++) wr(8'h28, pat_a(i));
        wr(8'h2C, 32'h3);
        for (int i = 5; i < NT - 1; i++) wr(8'h28, pat_a(i));
        rd(8'h2C, v); chk("R9 done not before last write", v, 32'h3);
        wr(8'h28, pat_a(NT - 1));
        rd(8'h2C, v); chk("R9 done after last write", v, 32'h7);
        peek(5, t); chk("R6 no restart tap5", {16'h0, t}, {16'h0, pat_a(5)[15:0]});
        for (int i = 0; i < NT; i++) begin
            peek(i, t);
            chk("R7 tap readback", {16'h0, t}, {16'h0, pat_a(i)[15:0]});
        end

        // R10 overrun
        wr(8'h28, 32'h0000_BEEF);
        wr(8'h28, 32'h0000_BEEF);
        peek(0, t);   chk("R10 tap0 unchanged", {16'h0, t}, {16'h0, pat_a(0)[15:0]});
        peek(127, t); chk("R10 tap127 unchanged", {16'h0, t}, {16'h0, pat_a(127)[15:0]});
        rd(8'h2C, v); chk("R10 done held", v, 32'h7);

        // R11 and R9 clear: bit 2 written as 1, load bit cleared
        wr(8'h2C, 32'h5);
        rd(8'h2C, v); chk("R11 done read-only, R9 cleared", v, 32'h1);

        // R8 writes with loading off
        wr(8'h28, 32'h0000_2222);
        wr(8'h28, 32'h0000_3333);
        peek(0, t); chk("R8 tap0 unchanged", {16'h0, t}, {16'h0, pat_a(0)[15:0]});
        peek(1, t); chk("R8 tap1 unchanged", {16'h0, t}, {16'h0, pat_a(1)[15:0]});
        rd(8'h2C, v); chk("R8 done stays 0", v, 32'h1);

        // R6 restart mid-load
        wr(8'h2C, 32'h3);
        for (int i = 0; i < 10; i++) wr(8'h28, pat_b(i));
        wr(8'h2C, 32'h1);
        wr(8'h2C, 32'h3);
        wr(8'h28, pat_b(100));
        wr(8'h28, pat_b(101));
        peek(0, t); chk("R6 restart tap0", {16'h0, t}, {16'h0, pat_b(100)[15:0]});
        peek(1, t); chk("R6 restart tap1", {16'h0, t}, {16'h0, pat_b(101)[15:0]});
        peek(2, t); chk("R6 restart tap2 old", {16'h0, t}, {16'h0, pat_b(2)[15:0]});
        rd(8'h2C, v); chk("R6 done clear after restart", v, 32'h3);
        for (int i = 2; i < NT; i++) wr(8'h28, pat_b(i));
        rd(8'h2C, v); chk("R9 done after second load", v, 32'h7);
        peek(127, t); chk("R7 tap127 second load", {16'h0, t}, {16'h0, pat_b(127)[15:0]});

        // R12 reads with no register behind them
        rd(8'h28, v); chk("R12 coef port read", v, 32'h0);
        rd(8'h18, v); chk("R12 offset 0x18 read", v, 32'h0);
        rd(8'h04, v); chk("R12 offset 0x04 read", v, 32'h0);

        // R5 disable
        wr(8'h2C, 32'h0);
        rd(8'h2C, v); chk("R5 ctrl cleared", v, 32'h0);
        chk("R5 st_enable off", {31'h0, st_enable}, 32'h0);

        cyc(1'b0, 1'b0, 8'h00, 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule